// File: doc/BRIEF.md
# Wake Event Status Controller

This block gathers sixteen single-bit wake sources into two byte-wide status registers. It drives one active-low event line toward the power-management logic. Each source sets its status bit on a rising edge only. The status bits record events whatever the enables hold, and the host clears them by writing ones.

Two enable registers choose which latched sources count as pending. A global status bit follows the pending condition even while the global enable is off. A global enable bit decides whether that condition reaches the output pin. The global status bit cannot be cleared while an enabled source is still pending.

The host reaches the registers through a plain byte-wide port with address, write strobe, write data and combinational read data. Every write completes in the cycle its strobe is high. The port has no back-pressure, so no valid/ready handshake is used. A battery power-on reset (`rst_n`, active low) returns every register to zero.

Top module: `wake_evt_ctrl`

## Requirements
- R1: A status bit sets in the clock edge that follows the first cycle in which its source is high after having been low. A source that stays high never sets the bit again once it has been cleared. The source history resets to low.
- R2: Status bits latch events regardless of the per-source enables and the global enable. While neither enable admits a source, its event leaves the global status at 0 and `evt_n` at 1.
- R3: Writing to a status register clears every bit written as 1. Bits written as 0 keep their value.
- R4: If a source rises in the same cycle as a write that clears its bit, the bit stays 1.
- R5: `src_in[i]` for i in 0..7 maps to bit i of address 0x0C. `src_in[i]` for i in 8..15 maps to bit i-8 of address 0x0D. The order of bits from 7 down to 0 at 0x0C is: device interrupt, clock alarm, ring, mouse, keyboard, ring indicator 1, ring indicator 2, infrared. At 0x0D, bits 7..0 hold general-purpose wake inputs 17..10.
- R6: Enable registers at 0x0E (sources 0..7) and 0x0F (sources 8..15) are fully read/write, with bit positions matching R5.
- R7: The global status bit (address 0x10, bit 0) becomes 1 one cycle after any source has both its status bit and its enable bit at 1, even when the global enable is 0.
- R8: Writing 1 to bit 0 of 0x10 clears the global status only when no enabled status bit is pending in that cycle. Otherwise the bit stays 1.
- R9: The global enable is bit 0 of 0x11. Other bits at 0x10 and 0x11, and every address outside 0x0C..0x11, read as 0.
- R10: `evt_n` is 0 exactly when the global enable and the global status are both 1. It returns to 1 once the global status clears.
- R11: After reset, all six registers read 0x00 and `evt_n` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Battery power-on reset, active low |
| src_in | input | 16 | Synchronous wake sources, active high |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| evt_n | output | 1 | Power-management event, active low |

## Verification
Every one of the sixteen sources is pulsed and then held high while the host clears its bit. This tells a true edge detector apart from a level latch and exposes any wrong bit or byte mapping. All 256 values are swept through both enable registers, and all 256 addresses are read to catch decode aliasing. Directed patterns cover the rest: zero-writes against one-writes, a clear that collides with a new edge, and global clears attempted with and without a pending source. Gated-off sources are checked against the global enable to separate the status path from the output path.

// File: rtl/wake_pkg.sv
package wake_pkg;
  localparam int BYTE_W   = 8;
  localparam int ADDR_W   = 8;
  localparam int N_BANK   = 2;
  localparam int STS_BASE = 12;  // 0x0C
  // Derived layout: status banks, then enable banks, then global status, then global enable.
  function automatic int en_base(input int sts_base, input int nbank);
    return sts_base + nbank;
  endfunction
  function automatic int gsts_ofs(input int sts_base, input int nbank);
    return sts_base + 2 * nbank;
  endfunction
  function automatic int gen_ofs(input int sts_base, input int nbank);
    return sts_base + 2 * nbank + 1;
  endfunction
endpackage

// File: rtl/wake_edge_det.sv
module wake_edge_det #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src,
  output logic [W-1:0] rise
);
  logic [W-1:0] hist_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) hist_q[i] <= 1'b0;
      else        hist_q[i] <= src[i];
    end
    assign rise[i] = src[i] & ~hist_q[i];
  end
endmodule

// File: rtl/wake_sts_bank.sv
module wake_sts_bank #(
  parameter int BW      = 8,
  parameter int AW      = 8,
  parameter int STS_OFS = 12,
  parameter int EN_OFS  = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [BW-1:0] wdata,
  input  logic [BW-1:0] rise,
  output logic [BW-1:0] sts,
  output logic [BW-1:0] en,
  output logic          pend
);
  localparam logic [AW-1:0] STS_A = AW'(STS_OFS);
  localparam logic [AW-1:0] EN_A  = AW'(EN_OFS);

  logic          sts_hit;
  logic          en_hit;
  logic [BW-1:0] clr_mask;

  assign sts_hit  = wr && (addr == STS_A);
  assign en_hit   = wr && (addr == EN_A);
  assign clr_mask = sts_hit ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts <= '0;
      en  <= '0;
    end else begin
      // a fresh edge outranks a simultaneous clear
      sts <= (sts & ~clr_mask) | rise;
      if (en_hit) en <= wdata;
    end
  end

  assign pend = |(sts & en);
endmodule

// File: rtl/wake_global.sv
module wake_global #(
  parameter int AW       = 8,
  parameter int BW       = 8,
  parameter int GSTS_OFS = 16,
  parameter int GEN_OFS  = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [BW-1:0] wdata,
  input  logic          pend_any,
  output logic          gs,
  output logic          ge,
  output logic          evt_n
);
  localparam logic [AW-1:0] GSTS_A = AW'(GSTS_OFS);
  localparam logic [AW-1:0] GEN_A  = AW'(GEN_OFS);

  logic gs_clr;
  assign gs_clr = wr && (addr == GSTS_A) && wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gs <= 1'b0;
      ge <= 1'b0;
    end else begin
      gs <= pend_any | (gs & ~gs_clr);
      if (wr && addr == GEN_A) ge <= wdata[0];
    end
  end

  assign evt_n = ~(ge & gs);
endmodule

// File: rtl/wake_evt_ctrl.sv
module wake_evt_ctrl
  import wake_pkg::*;
#(
  parameter int NBANK = N_BANK,
  parameter int BW    = BYTE_W,
  parameter int AW    = ADDR_W,
  parameter int SBASE = STS_BASE
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NBANK*BW-1:0] src_in,
  input  logic [AW-1:0]       reg_addr,
  input  logic                reg_wr,
  input  logic [BW-1:0]       reg_wdata,
  output logic [BW-1:0]       reg_rdata,
  output logic                evt_n
);
  localparam int NSRC  = NBANK * BW;
  localparam int EBASE = en_base(SBASE, NBANK);
  localparam int GSOFS = gsts_ofs(SBASE, NBANK);
  localparam int GEOFS = gen_ofs(SBASE, NBANK);

  logic [NSRC-1:0]  rise_all;
  logic [NSRC-1:0]  sts_all;
  logic [NSRC-1:0]  en_all;
  logic [NBANK-1:0] pend_bank;
  logic             pend_any;
  logic             gs_q;
  logic             ge_q;

  wake_edge_det #(.W(NSRC)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .src  (src_in),
    .rise (rise_all)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    wake_sts_bank #(
      .BW     (BW),
      .AW     (AW),
      .STS_OFS(SBASE + b),
      .EN_OFS (EBASE + b)
    ) u_bank (
      .clk  (clk),
      .rst_n(rst_n),
      .wr   (reg_wr),
      .addr (reg_addr),
      .wdata(reg_wdata),
      .rise (rise_all[b*BW +: BW]),
      .sts  (sts_all[b*BW +: BW]),
      .en   (en_all[b*BW +: BW]),
      .pend (pend_bank[b])
    );
  end

  assign pend_any = |pend_bank;

  wake_global #(
    .AW      (AW),
    .BW      (BW),
    .GSTS_OFS(GSOFS),
    .GEN_OFS (GEOFS)
  ) u_glob (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (reg_wr),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .pend_any(pend_any),
    .gs      (gs_q),
    .ge      (ge_q),
    .evt_n   (evt_n)
  );

  always_comb begin
    reg_rdata = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (reg_addr == AW'(SBASE + b)) reg_rdata = sts_all[b*BW +: BW];
      if (reg_addr == AW'(EBASE + b)) reg_rdata = en_all[b*BW +: BW];
    end
    if (reg_addr == AW'(GSOFS)) reg_rdata = {{(BW-1){1'b0}}, gs_q};
    if (reg_addr == AW'(GEOFS)) reg_rdata = {{(BW-1){1'b0}}, ge_q};
  end
endmodule

// File: rtl/wake_evt_ctrl_chk.sv
module wake_evt_ctrl_chk #(
  parameter int NBANK = 2,
  parameter int BW    = 8,
  parameter int AW    = 8,
  parameter int SBASE = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NBANK*BW-1:0] src_in,
  input logic [AW-1:0]       reg_addr,
  input logic                reg_wr,
  input logic [BW-1:0]       reg_wdata,
  input logic [NBANK*BW-1:0] sts_all,
  input logic [NBANK*BW-1:0] en_all,
  input logic                pend_any,
  input logic                gs_q,
  input logic                ge_q,
  input logic                evt_n
);
  localparam int NSRC  = NBANK * BW;
  localparam int GSOFS = SBASE + 2 * NBANK;

  // checker-owned copy of the previous source levels
  logic [NSRC-1:0] src_d1;
  logic [NSRC-1:0] edge_ok;
  always_ff @(posedge clk) begin
    if (!rst_n) src_d1 <= '0;
    else        src_d1 <= src_in;
  end
  assign edge_ok = src_in & ~src_d1;

  assert_edge_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts_all & ~$past(sts_all)) & ~$past(edge_ok)) == '0);

  assert_edge_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(edge_ok) & ~sts_all) == '0);

  for (genvar b = 0; b < NBANK; b++) begin : g_w1c
    assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == AW'(SBASE + b)) |=>
        ((sts_all[b*BW +: BW] & $past(reg_wdata) & ~$past(edge_ok[b*BW +: BW])) == '0));
    assert_zero_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == AW'(SBASE + b)) |=>
        (($past(sts_all[b*BW +: BW]) & ~$past(reg_wdata) & ~sts_all[b*BW +: BW]) == '0));
  end

  assert_gs_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pend_any |=> gs_q);

  assert_gs_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == AW'(GSOFS) && reg_wdata[0] && !pend_any) |=> !gs_q);

  assert_out_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(evt_n) |-> (ge_q && gs_q));

  assert_out_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ge_q |-> evt_n);
endmodule

bind wake_evt_ctrl wake_evt_ctrl_chk #(
  .NBANK(NBANK), .BW(BW), .AW(AW), .SBASE(SBASE)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .src_in   (src_in),
  .reg_addr (reg_addr),
  .reg_wr   (reg_wr),
  .reg_wdata(reg_wdata),
  .sts_all  (sts_all),
  .en_all   (en_all),
  .pend_any (pend_any),
  .gs_q     (gs_q),
  .ge_q     (ge_q),
  .evt_n    (evt_n)
);

// File: tb/wake_evt_ctrl_tb.sv
module wake_evt_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] src_in = '0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        evt_n;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;  // 50 MHz

  wake_evt_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_n(evt_n)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
    reg_addr = a;
    #1;
    check(req, int'(reg_rdata), int'(exp));
  endtask

  task automatic pulse(input logic [15:0] m);
    @(negedge clk); src_in = src_in | m;
    @(negedge clk); src_in = src_in & ~m;
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    idle(3);
    // R11: reset state
    for (int a = 12; a <= 17; a++) rd_chk("R11 reset value", 8'(a), 8'h00);
    check("R11 evt_n idle", int'(evt_n), 1);
    rst_n = 1'b1;
    idle(2);

    // R9: address sweep, unmapped reads are zero
    for (int a = 0; a < 256; a++)
      if (a < 12 || a > 17) rd_chk("R9 unmapped read", 8'(a), 8'h00);

    // R6: full value sweep on both enable registers
    for (int b = 0; b < 2; b++)
      for (int v = 0; v < 256; v++) begin
        wr_reg(8'(14 + b), 8'(v));
        rd_chk("R6 enable readback", 8'(14 + b), 8'(v));
      end
    wr_reg(8'h0E, 8'h00);
    wr_reg(8'h0F, 8'h00);

    // R9: reserved bits
    wr_reg(8'h11, 8'hFE);
    rd_chk("R9 gen reserved", 8'h11, 8'h00);
    wr_reg(8'h11, 8'hFF);
    rd_chk("R9 gen bit0", 8'h11, 8'h01);

    // R1/R2/R5: every source, edge then steady high across a clear
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); src_in = 16'(1) << i;
      idle(3);
      rd_chk("R5 status low byte", 8'h0C, (i < 8)  ? 8'(1 << i) : 8'h00);
      rd_chk("R5 status high byte", 8'h0D, (i >= 8) ? 8'(1 << (i - 8)) : 8'h00);
      rd_chk("R2 gs stays 0 with enables off", 8'h10, 8'h00);
      check("R2 evt_n with enables off", int'(evt_n), 1);
      wr_reg(8'h0C, 8'hFF);
      wr_reg(8'h0D, 8'hFF);
      idle(2);
      rd_chk("R1 steady high no reset low", 8'h0C, 8'h00);
      rd_chk("R1 steady high no reset high", 8'h0D, 8'h00);
      @(negedge clk); src_in = '0;
    end
    wr_reg(8'h11, 8'h00);

    // R3: zero-writes keep, one-writes clear
    pulse(16'h0209);
    idle(1);
    rd_chk("R3 setup low", 8'h0C, 8'h09);
    rd_chk("R3 setup high", 8'h0D, 8'h02);
    wr_reg(8'h0C, 8'h00);
    wr_reg(8'h0D, 8'h00);
    rd_chk("R3 zero write low", 8'h0C, 8'h09);
    rd_chk("R3 zero write high", 8'h0D, 8'h02);
    wr_reg(8'h0C, 8'h01);
    rd_chk("R3 partial clear", 8'h0C, 8'h08);
    wr_reg(8'h0C, 8'hFF);
    wr_reg(8'h0D, 8'hFF);
    rd_chk("R3 full clear low", 8'h0C, 8'h00);
    rd_chk("R3 full clear high", 8'h0D, 8'h00);

    // R4: edge collides with clear
    @(negedge clk);
    src_in = 16'h0020; reg_wr = 1'b1; reg_addr = 8'h0C; reg_wdata = 8'h20;
    @(negedge clk);
    reg_wr = 1'b0;
    rd_chk("R4 edge beats clear", 8'h0C, 8'h20);
    wr_reg(8'h0C, 8'h20);
    rd_chk("R4 later clear", 8'h0C, 8'h00);
    @(negedge clk); src_in = '0;

    // R7/R8: global status with global enable off
    wr_reg(8'h0E, 8'h04);
    pulse(16'h0004);
    idle(2);
    rd_chk("R7 gs sets with gen off", 8'h10, 8'h01);
    check("R10 evt_n gated by gen", int'(evt_n), 1);
    wr_reg(8'h10, 8'h01);
    rd_chk("R8 clear refused while pending", 8'h10, 8'h01);
    wr_reg(8'h0C, 8'h04);
    wr_reg(8'h10, 8'hFE);
    rd_chk("R8 bit0 zero ignored", 8'h10, 8'h01);
    wr_reg(8'h10, 8'h01);
    rd_chk("R8 clear accepted", 8'h10, 8'h00);
    wr_reg(8'h0E, 8'h00);

    // R10: output path
    wr_reg(8'h11, 8'h01);
    wr_reg(8'h0F, 8'h10);
    pulse(16'h1000);
    idle(2);
    check("R10 evt_n asserted", int'(evt_n), 0);
    wr_reg(8'h0D, 8'h10);
    check("R10 evt_n held until gs clear", int'(evt_n), 0);
    wr_reg(8'h10, 8'h01);
    check("R10 evt_n released", int'(evt_n), 1);
    pulse(16'h2000);
    idle(2);
    check("R10 masked source keeps evt_n high", int'(evt_n), 1);
    rd_chk("R2 masked source still recorded", 8'h0D, 8'h20);
    wr_reg(8'h0D, 8'hFF);

    // R11: reset mid-run
    wr_reg(8'h0E, 8'hAA);
    pulse(16'h0002);
    idle(2);
    check("R11 pre-reset evt_n", int'(evt_n), 0);
    @(negedge clk); rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 12; a <= 17; a++) rd_chk("R11 reset clears", 8'(a), 8'h00);
    check("R11 evt_n after reset", int'(evt_n), 1);

    summary();
  end
endmodule